// File: doc/BRIEF.md
# SDRAM Bank Command Sequencer

This block sits between a simple request port and the command pins of a single-data-rate SDRAM. Each request names a bank, a row and a column. It either writes one data word under a per-byte mask or reads one word back. The block can also close every bank at once. The sequencer turns each request into the minimum legal series of PRECHARGE, ACTIVE and column commands, and drives them on the active-low row strobe, column strobe and write enable, together with a bank select and an address bus.

Every bank has its own tracker. A tracker remembers whether a row is open and which row it is. It also runs four countdowns: activate-to-column, activate-to-precharge, precharge-to-activate and write recovery. A request to the open row goes straight to the column command. A request to a different row first closes the bank, then reopens it at the new row. Read data is handed back on a valid strobe that lines up with the burst coming back from the memory. Write data and byte masks are driven on the data bus after a fixed write latency.

Requests use a valid/ready handshake and are served strictly in order, one at a time.

Top module: `sdram_bank_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, the command pins show NOP, `req_ready` is high, `rd_valid` is low and `sd_dq_oe` is low.
- R2: Commands are encoded on {`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as NOP=111, ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010, and no other pattern ever appears. At most one command is issued per cycle.
- R3: A READ or WRITE goes only to a bank whose open row equals the requested row, and at least T_RCD cycles after the ACTIVE that opened it.
- R4: For a READ issued in cycle n, `rd_valid` is high in exactly the cycles n+CL through n+CL+BL-1, and the first of those beats carries the requested word. Read and write bursts never overlap on the data bus.
- R5: A PRECHARGE closing a bank comes at least T_RAS cycles after the ACTIVE that opened it.
- R6: An ACTIVE to a bank comes at least T_RP cycles after the PRECHARGE that closed it.
- R7: For a WRITE issued in cycle n, `sd_dq_oe` is high in cycles n+WL through n+WL+BL-1, and no PRECHARGE of that bank comes earlier than T_WR cycles after the last of those beats.
- R8: `sd_dm` bit i high means byte i is left unchanged. The first write beat carries `req_wmask`, and every later beat of the burst is fully masked, so exactly one word is written.
- R9: A request to the row already open in its bank (row hit) issues only the column command, with no PRECHARGE or ACTIVE.
- R10: A request to a bank holding a different open row issues PRECHARGE with address bit 10 low, then ACTIVE, then the column command.
- R11: A close-all request (`req_op`=2) issues one PRECHARGE with address bit 10 high, only once every open bank meets T_RAS and T_WR. After it, every bank needs an ACTIVE again.
- R12: `req_op` is 0 for read and 1 for write. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the request's last command has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 2 | 0 read, 1 write, 2 close all banks |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_wdata | input | DATA_W | Write word |
| req_wmask | input | DATA_W/8 | Byte mask, 1 keeps the byte |
| rd_valid | output | 1 | Read beat on `rd_data` |
| rd_data | output | DATA_W | Read beat |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Row, column or precharge-scope address |
| sd_dq_out | output | DATA_W | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dm | output | DATA_W/8 | Data mask to memory |
| sd_dq_in | input | DATA_W | Read data from memory |

## Verification
The bench builds the block with four banks, a burst of 4, CAS latency 2, write latency 1, T_RCD 2, T_RAS 5, T_RP 2 and T_WR 2. The short burst and latencies let a write be followed at once by a conflicting request to the same bank. That places the write-recovery and activate-to-precharge windows right where a miscount would show up. A behavioural memory in the bench checks every command against those windows. Each returned word is compared with a shadow copy built from the requests.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010
    } sdq_cmd_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_CLOSE = 2'd2
    } sdq_op_e;

    localparam int ALL_BANK_BIT = 10;

    // countdown that rests at zero
    function automatic logic [15:0] dec_sat(input logic [15:0] v);
        return (v == 16'd0) ? 16'd0 : v - 16'd1;
    endfunction

endpackage

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
    parameter int ROW_W   = 13,
    parameter int CNT_W   = 6,
    parameter int T_RCD   = 3,
    parameter int T_RAS   = 6,
    parameter int T_RP    = 3,
    parameter int WR_HOLD = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic             col_i,
    input  logic             wr_i,
    input  logic [ROW_W-1:0] act_row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             col_ok_o,
    output logic             pre_ok_o,
    output logic             act_ok_o
);
    import sdram_seq_pkg::*;

    logic [CNT_W-1:0] rcd_q, ras_q, rp_q, wrr_q;
    logic             open_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
            rcd_q  <= '0;
            ras_q  <= '0;
            rp_q   <= '0;
            wrr_q  <= '0;
        end else begin
            rcd_q <= CNT_W'(dec_sat(16'(rcd_q)));
            ras_q <= CNT_W'(dec_sat(16'(ras_q)));
            rp_q  <= CNT_W'(dec_sat(16'(rp_q)));
            wrr_q <= CNT_W'(dec_sat(16'(wrr_q)));
            if (act_i) begin
                open_q <= 1'b1;
                row_q  <= act_row_i;
                rcd_q  <= CNT_W'(T_RCD - 1);
                ras_q  <= CNT_W'(T_RAS - 1);
            end
            if (pre_i && open_q) begin
                open_q <= 1'b0;
                rp_q   <= CNT_W'(T_RP - 1);
            end
            if (wr_i) wrr_q <= CNT_W'(WR_HOLD);
        end
    end

    assign open_o   = open_q;
    assign row_o    = row_q;
    assign col_ok_o = open_q && (rcd_q == '0);
    assign pre_ok_o = !open_q || ((ras_q == '0) && (wrr_q == '0));
    assign act_ok_o = !open_q && (rp_q == '0);

    p_col_open_r3: assert property (@(posedge clk) disable iff (rst)
        col_i |-> (open_q && rcd_q == '0));
    p_pre_ras_wr_r5: assert property (@(posedge clk) disable iff (rst)
        (pre_i && open_q) |-> (ras_q == '0 && wrr_q == '0));
    p_act_rp_r6: assert property (@(posedge clk) disable iff (rst)
        act_i |-> (!open_q && rp_q == '0));

endmodule

// File: rtl/sdram_burst_io.sv
module sdram_burst_io #(
    parameter int DATA_W = 16,
    parameter int BL     = 8,
    parameter int CL     = 3,
    parameter int WL     = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_rd_i,
    input  logic                start_wr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [DATA_W/8-1:0] wmask_i,
    output logic                bus_free_o,
    output logic                rd_valid_o,
    output logic                dq_oe_o,
    output logic [DATA_W-1:0]   dq_out_o,
    output logic [DATA_W/8-1:0] dm_o
);
    localparam int MASK_W = DATA_W / 8;
    localparam int RSPAN  = CL + BL;
    localparam int WSPAN  = WL + BL;
    localparam int BCNT_W = $clog2((RSPAN > WSPAN ? RSPAN : WSPAN) + 1);

    logic [BCNT_W-1:0] rd_cnt_q, wr_cnt_q, busy_q;
    logic [DATA_W-1:0] wdata_q;
    logic [MASK_W-1:0] wmask_q;
    logic              rd_act, wr_act, wr_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_cnt_q <= '0;
            wr_cnt_q <= '0;
            busy_q   <= '0;
            wdata_q  <= '0;
            wmask_q  <= '1;
        end else begin
            if (rd_cnt_q != '0) rd_cnt_q <= rd_cnt_q - 1'b1;
            if (wr_cnt_q != '0) wr_cnt_q <= wr_cnt_q - 1'b1;
            if (busy_q != '0)   busy_q   <= busy_q - 1'b1;
            if (start_rd_i) begin
                rd_cnt_q <= BCNT_W'(RSPAN);
                busy_q   <= BCNT_W'(RSPAN - 1);
            end
            if (start_wr_i) begin
                wr_cnt_q <= BCNT_W'(WSPAN);
                busy_q   <= BCNT_W'(WSPAN - 1);
                wdata_q  <= wdata_i;
                wmask_q  <= wmask_i;
            end
        end
    end

    assign rd_act     = (rd_cnt_q != '0) && (rd_cnt_q <= BCNT_W'(BL));
    assign wr_act     = (wr_cnt_q != '0) && (wr_cnt_q <= BCNT_W'(BL));
    assign wr_first   = (wr_cnt_q == BCNT_W'(BL));
    assign bus_free_o = (busy_q == '0);
    assign rd_valid_o = rd_act;
    assign dq_oe_o    = wr_act;
    assign dq_out_o   = wdata_q;
    assign dm_o       = (wr_act && wr_first) ? wmask_q : '1;

    p_bus_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(rd_act && wr_act));
    p_start_free_r4: assert property (@(posedge clk) disable iff (rst)
        (start_rd_i || start_wr_i) |-> bus_free_o);

endmodule

// File: rtl/sdram_bank_seq.sv
module sdram_bank_seq
    import sdram_seq_pkg::*;
#(
    parameter int NBANK  = 4,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 9,
    parameter int DATA_W = 16,
    parameter int BL     = 8,
    parameter int CL     = 3,
    parameter int WL     = 1,
    parameter int T_RCD  = 3,
    parameter int T_RAS  = 6,
    parameter int T_RP   = 3,
    parameter int T_WR   = 2,
    localparam int BANK_W = $clog2(NBANK),
    localparam int MASK_W = DATA_W / 8,
    localparam int ADDR_W = (ROW_W > ALL_BANK_BIT + 1) ? ROW_W : ALL_BANK_BIT + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [MASK_W-1:0] req_wmask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    output logic [MASK_W-1:0] sd_dm,
    input  logic [DATA_W-1:0] sd_dq_in
);
    localparam int WR_HOLD = WL + BL - 2 + T_WR;
    localparam int CNT_W   = $clog2(T_RCD + T_RAS + T_RP + WR_HOLD + 2);

    typedef struct packed {
        sdq_op_e           op;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [MASK_W-1:0] wmask;
    } req_t;

    req_t              rq_q;
    logic              pend_q;
    sdq_cmd_e          nxt_cmd, cmd_q;
    logic              nxt_all, nxt_done, bus_free;
    logic [ADDR_W-1:0] nxt_addr, addr_q;
    logic [BANK_W-1:0] ba_q;

    logic [NBANK-1:0]  bk_open, col_ok, pre_ok, act_ok;
    logic [ROW_W-1:0]  bk_row [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic here;
        assign here = (rq_q.bank == BANK_W'(b));
        sdram_bank_track #(
            .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
            .T_RP(T_RP), .WR_HOLD(WR_HOLD)
        ) u_trk (
            .clk      (clk),
            .rst      (rst),
            .act_i    (nxt_cmd == CMD_ACT && here),
            .pre_i    (nxt_cmd == CMD_PRE && (nxt_all || here)),
            .col_i    ((nxt_cmd == CMD_RD || nxt_cmd == CMD_WR) && here),
            .wr_i     (nxt_cmd == CMD_WR && here),
            .act_row_i(rq_q.row),
            .open_o   (bk_open[b]),
            .row_o    (bk_row[b]),
            .col_ok_o (col_ok[b]),
            .pre_ok_o (pre_ok[b]),
            .act_ok_o (act_ok[b])
        );
    end

    // pick the single command for this cycle
    always_comb begin
        nxt_cmd  = CMD_NOP;
        nxt_all  = 1'b0;
        nxt_done = 1'b0;
        if (pend_q) begin
            if (rq_q.op == OP_CLOSE) begin
                if (&pre_ok) begin
                    nxt_cmd  = CMD_PRE;
                    nxt_all  = 1'b1;
                    nxt_done = 1'b1;
                end
            end else if (!bk_open[rq_q.bank]) begin
                if (act_ok[rq_q.bank]) nxt_cmd = CMD_ACT;
            end else if (bk_row[rq_q.bank] != rq_q.row) begin
                if (pre_ok[rq_q.bank]) nxt_cmd = CMD_PRE;
            end else if (col_ok[rq_q.bank] && bus_free) begin
                nxt_cmd  = (rq_q.op == OP_WR) ? CMD_WR : CMD_RD;
                nxt_done = 1'b1;
            end
        end
    end

    always_comb begin
        nxt_addr = '0;
        case (nxt_cmd)
            CMD_ACT: nxt_addr = ADDR_W'(rq_q.row);
            CMD_PRE: nxt_addr[ALL_BANK_BIT] = nxt_all;
            CMD_RD, CMD_WR: nxt_addr = ADDR_W'(rq_q.col);
            default: nxt_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            rq_q   <= '0;
            cmd_q  <= CMD_NOP;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            cmd_q  <= nxt_cmd;
            ba_q   <= rq_q.bank;
            addr_q <= nxt_addr;
            if (nxt_done) pend_q <= 1'b0;
            if (req_valid && !pend_q) begin
                pend_q <= 1'b1;
                rq_q   <= '{op: sdq_op_e'(req_op), bank: req_bank, row: req_row,
                           col: req_col, wdata: req_wdata, wmask: req_wmask};
            end
        end
    end

    sdram_burst_io #(.DATA_W(DATA_W), .BL(BL), .CL(CL), .WL(WL)) u_io (
        .clk       (clk),
        .rst       (rst),
        .start_rd_i(nxt_cmd == CMD_RD),
        .start_wr_i(nxt_cmd == CMD_WR),
        .wdata_i   (rq_q.wdata),
        .wmask_i   (rq_q.wmask),
        .bus_free_o(bus_free),
        .rd_valid_o(rd_valid),
        .dq_oe_o   (sd_dq_oe),
        .dq_out_o  (sd_dq_out),
        .dm_o      (sd_dm)
    );

    assign req_ready = !pend_q;
    assign rd_data   = sd_dq_in;
    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba     = ba_q;
    assign sd_addr   = addr_q;

    p_cmd_legal_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_q inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_PRE});
    p_take_holds_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sdram_bank_seq_tb.sv
module sdram_bank_seq_tb;
    localparam int NB = 4, RW = 13, CW = 9, DW = 16, MW = 2;
    localparam int BL = 4, CL = 2, WL = 1, TRCD = 2, TRAS = 5, TRP = 2, TWR = 2;
    localparam int AW = 13;

    logic clk = 0, rst = 1;
    always #10 clk = ~clk;

    logic          req_valid = 0, req_ready;
    logic [1:0]    req_op = 0;
    logic [1:0]    req_bank = 0;
    logic [RW-1:0] req_row = 0;
    logic [CW-1:0] req_col = 0;
    logic [DW-1:0] req_wdata = 0;
    logic [MW-1:0] req_wmask = 0;
    logic          rd_valid, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [DW-1:0] rd_data, sd_dq_out;
    logic [DW-1:0] sd_dq_in = 0;
    logic [1:0]    sd_ba;
    logic [AW-1:0] sd_addr;
    logic [MW-1:0] sd_dm;

    sdram_bank_seq #(.NBANK(NB), .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .BL(BL),
        .CL(CL), .WL(WL), .T_RCD(TRCD), .T_RAS(TRAS), .T_RP(TRP), .T_WR(TWR)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_wmask(req_wmask), .rd_valid(rd_valid),
        .rd_data(rd_data), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
        .sd_dm(sd_dm), .sd_dq_in(sd_dq_in));

    int checks = 0, errors = 0;
    int n_act = 0, n_pre = 0, n_pre_all = 0;
    int hist[$];
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] mem[int];
    logic [DW-1:0] shadow[int];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int key(input int b, input int r, input int c);
        return (b << 22) | (r << 9) | c;
    endfunction

    // ---------------- behavioural memory and timing checker ----------------
    int cyc = 0;
    bit opn[NB];
    int orow[NB], t_act[NB], t_pre[NB], t_lastwr[NB];
    int rd_start = -100, rd_base = 0, wr_start = -100, wr_base = 0;

    initial for (int i = 0; i < NB; i++) begin
        opn[i] = 0; t_act[i] = -100; t_pre[i] = -100; t_lastwr[i] = -100; orow[i] = 0;
    end

    always @(negedge clk) begin
        logic [2:0] cmd;
        int b, beat, k;
        logic [DW-1:0] w;
        cyc++;
        cmd = {sd_ras_n, sd_cas_n, sd_we_n};
        b = int'(sd_ba);
        if (!rst) begin
            chk(cmd inside {3'b111, 3'b011, 3'b101, 3'b100, 3'b010}, "R2 legal code", cmd, 7);
            if (cmd != 3'b111) hist.push_back(int'(cmd));
            case (cmd)
                3'b011: begin
                    n_act++;
                    chk(!opn[b], "R6 act to closed bank", opn[b], 0);
                    chk(cyc - t_pre[b] >= TRP, "R6 tRP", cyc - t_pre[b], TRP);
                    opn[b] = 1; orow[b] = int'(sd_addr); t_act[b] = cyc;
                end
                3'b101, 3'b100: begin
                    chk(opn[b], "R3 column to open bank", opn[b], 1);
                    chk(cyc - t_act[b] >= TRCD, "R3 tRCD", cyc - t_act[b], TRCD);
                    if (cmd == 3'b101) begin
                        rd_start = cyc + CL; rd_base = key(b, orow[b], int'(sd_addr));
                    end else begin
                        wr_start = cyc + WL; wr_base = key(b, orow[b], int'(sd_addr));
                        t_lastwr[b] = wr_start + BL - 1;
                    end
                end
                3'b010: begin
                    n_pre++;
                    if (sd_addr[10]) n_pre_all++;
                    for (int i = 0; i < NB; i++) begin
                        if ((sd_addr[10] || i == b) && opn[i]) begin
                            chk(cyc - t_act[i] >= TRAS, "R5 tRAS", cyc - t_act[i], TRAS);
                            chk(cyc - t_lastwr[i] >= TWR, "R7 tWR", cyc - t_lastwr[i], TWR);
                            opn[i] = 0; t_pre[i] = cyc;
                        end
                    end
                end
                default: ;
            endcase
            // write beats
            beat = cyc - wr_start;
            chk(sd_dq_oe == (beat >= 0 && beat < BL), "R7 write window", sd_dq_oe, (beat >= 0 && beat < BL));
            if (beat >= 0 && beat < BL) begin
                if (beat > 0) chk(sd_dm == 2'b11, "R8 later beats masked", sd_dm, 3);
                k = wr_base + beat;
                w = mem.exists(k) ? mem[k] : '0;
                for (int y = 0; y < MW; y++) if (!sd_dm[y]) w[y*8 +: 8] = sd_dq_out[y*8 +: 8];
                mem[k] = w;
            end
            // read beats
            beat = cyc - rd_start;
            if (beat >= 0 && beat < BL) begin
                k = rd_base + beat;
                sd_dq_in = mem.exists(k) ? mem[k] : '0;
            end else sd_dq_in = 16'hDEAD;
            #1;
            chk(rd_valid == (beat >= 0 && beat < BL), "R4 read window", rd_valid, (beat >= 0 && beat < BL));
            if (rd_valid && beat == 0) begin
                if (exp_q.size() == 0) chk(0, "R4 unexpected read", rd_data, 0);
                else begin
                    w = exp_q.pop_front();
                    chk(rd_data === w, "R4 R8 read word", rd_data, w);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send(input int op, input int b, input int r, input int c,
                        input logic [DW-1:0] d, input logic [MW-1:0] m);
        int k;
        logic [DW-1:0] w;
        k = key(b, r, c);
        w = shadow.exists(k) ? shadow[k] : '0;
        if (op == 1) begin
            for (int y = 0; y < MW; y++) if (!m[y]) w[y*8 +: 8] = d[y*8 +: 8];
            shadow[k] = w;
        end else if (op == 0) exp_q.push_back(w);
        @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_bank = 2'(b); req_row = RW'(r);
        req_col = CW'(c); req_wdata = d; req_wmask = m;
        #2;
        while (!req_ready) begin @(negedge clk); #2; end
        @(negedge clk);
        req_valid = 0;
        #2;
        chk(!req_ready, "R12 ready low while pending", req_ready, 0);
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    initial begin
        int a0, p0, pa0;
        repeat (3) @(posedge clk);
        #2;
        chk({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1 nop in reset", {sd_ras_n, sd_cas_n, sd_we_n}, 7);
        rst = 0;
        @(negedge clk);
        chk(req_ready && !rd_valid && !sd_dq_oe, "R1 idle after reset",
            {req_ready, rd_valid, sd_dq_oe}, 3'b100);

        // R9 row hit
        send(1, 0, 5, 8, 16'h1111, 2'b00);
        settle();
        a0 = n_act; p0 = n_pre;
        send(0, 0, 5, 8, 0, 0);
        settle();
        chk(n_act == a0 && n_pre == p0, "R9 hit no act/pre", n_act - a0 + n_pre - p0, 0);

        // R8 masks
        send(1, 0, 5, 9, 16'hAAAA, 2'b00);
        send(1, 0, 5, 9, 16'h1234, 2'b10);
        send(1, 0, 5, 20, 16'h5555, 2'b00);
        send(1, 0, 5, 19, 16'h7777, 2'b00);
        send(0, 0, 5, 9, 0, 0);
        send(0, 0, 5, 20, 0, 0);
        send(0, 0, 5, 19, 0, 0);
        settle();

        // R10 conflict ordering
        a0 = n_act; p0 = n_pre; pa0 = n_pre_all;
        send(0, 0, 6, 0, 0, 0);
        settle();
        chk(n_act == a0 + 1 && n_pre == p0 + 1 && n_pre_all == pa0, "R10 counts",
            (n_act - a0) * 16 + n_pre - p0, 17);
        chk(hist[$-2] == 3'b010 && hist[$-1] == 3'b011 && hist[$] == 3'b101,
            "R10 order", hist[$-2] * 64 + hist[$-1] * 8 + hist[$], 2 * 64 + 3 * 8 + 5);

        // several banks back to back
        a0 = n_act;
        send(1, 1, 1, 4, 16'hB1B1, 2'b00);
        send(1, 2, 2, 4, 16'hB2B2, 2'b00);
        send(1, 3, 3, 4, 16'hB3B3, 2'b00);
        send(0, 1, 1, 4, 0, 0);
        send(0, 2, 2, 4, 0, 0);
        send(0, 3, 3, 4, 0, 0);
        settle();
        chk(n_act == a0 + 3, "R9 one act per bank", n_act - a0, 3);

        // R7 write then immediate conflict on same bank
        send(1, 1, 1, 5, 16'hC0DE, 2'b00);
        send(0, 1, 9, 0, 0, 0);
        settle();

        // R11 close all, right after a write
        send(1, 2, 2, 6, 16'h4242, 2'b00);
        pa0 = n_pre_all;
        send(2, 0, 0, 0, 0, 0);
        settle();
        chk(n_pre_all == pa0 + 1, "R11 one precharge-all", n_pre_all - pa0, 1);
        a0 = n_act;
        send(0, 2, 2, 6, 0, 0);
        settle();
        chk(n_act == a0 + 1, "R11 reopen needed", n_act - a0, 1);
        chk(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule